// File: doc/BRIEF.md
# PCI Endpoint Type 0 Configuration Header

This block holds the 64-byte Type 0 configuration header of a PCI endpoint function, which sits at the bottom of a 4 KiB configuration window. A request port carries a dword address, byte enables, write data and a read/write flag. Read data comes back combinationally in the same cycle. Addresses from byte offset 0x40 up to the top of the window are not decoded here. They are forwarded unchanged to a capability-space port, and that port's read data is returned in their place.

Each header field has its own write rule:
- The command word accepts only its six writable bits.
- The error flags in the status word clear when software writes a one to them.
- The six base address registers (BARs) store only the bits that their region size leaves writable.

The size masks are computed at elaboration from per-slot kind and size parameters. A 64-bit memory BAR lends the upper half of its size mask to the empty slot that follows it. The identity fields are parameters and cannot be written.

Downstream address decode reads the live command bits and all six BAR values from dedicated outputs. Error events raised by the function set the status error flags through a separate input.

Top module: `cfg_header_regs`

## Requirements
- R1: Reset (synchronous, active-low) sets the following state. The command word is 0 and every status error flag is 0. Each BAR holds only its type bits: an I/O slot reads 0x00000001, a 64-bit memory slot reads 0x00000004, and every other slot reads 0.
- R2: A write to dword 1 with byte enables [1:0] both set updates only command bits 10, 8, 6, 2, 1 and 0 (mask 0x0547). All other command bits stay 0, and a write with a partial low half is ignored. The command word reads at dword 1 bits [15:0] and drives `cmdOut`.
- R3: The status word reads at dword 1 bits [31:16]. Its error flags are bits 15, 14, 13, 12, 11 and 8, set by `errSet[5]` through `errSet[1]` (to bits 15 down to 11) and by `errSet[0]` (to bit 8). A write to dword 1 with byte enables [3:2] both set clears each flag whose data bit is 1. Ones written to any other status bit have no effect. A flag that is set and cleared in the same cycle stays set.
- R4: A write to dwords 4 to 9 (BAR slots 0 to 5) with all four byte enables set stores (old AND NOT mask) OR (data AND mask). Any other byte enable pattern leaves the BAR unchanged. BAR values read back at those dwords and on `barOut`, with slot i at bits [32i+31:32i].
- R5: A slot's mask is NOT (size rounded up to a power of two, minus 1). The minimum size is 4 bytes for an I/O slot and 4 KiB for a memory slot. An empty slot has mask 0 unless R6 applies. Kind codes in `BAR_KINDS[2i+1:2i]` are: 0 empty, 1 I/O, 2 32-bit memory, 3 64-bit memory.
- R6: An empty slot directly after a 64-bit memory slot takes the upper 32 bits of that slot's 64-bit mask as its own mask.
- R7: With capabilities present (`HAS_CAPS`=1), status bit 4 reads 1 and dword 13 reads 0x00000040.
- R8: Writes to dword 12 (expansion ROM), and to any header dword other than 1 and 4 to 9, change no state. Dword 12 reads 0.
- R9: Dword 0 reads {device ID, vendor ID}. Dword 2 reads {class code, revision}. Dword 11 reads {subsystem ID, subsystem vendor ID}. Dword 15 reads the interrupt pin in bits [15:8]. Dword 3 reads 0 (header type 0), and the other reserved dwords read 0.
- R10: A request at dword address 16 or above does the following:
  - It raises `capValid` in the same cycle, with address, write flag, byte enables and data passed through.
  - Its read returns `capRdata`.
  - It changes no header state.
  - Header-range requests never raise `capValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 10 | Dword address within the 4 KiB window |
| reqByteEn | input | 4 | Byte enables of the dword |
| reqWdata | input | 32 | Write data |
| rspRdata | output | 32 | Read data, valid in the request cycle |
| errSet | input | 6 | Error events setting status flags 15..11 and 8 |
| cmdOut | output | 16 | Current command word |
| barOut | output | 192 | Six BAR values, slot i at bits [32i+31:32i] |
| capValid | output | 1 | Request forwarded to capability space |
| capWrite | output | 1 | Forwarded write flag |
| capAddr | output | 10 | Forwarded dword address |
| capByteEn | output | 4 | Forwarded byte enables |
| capWdata | output | 32 | Forwarded write data |
| capRdata | input | 32 | Capability-space read data |

## Verification
The bench builds the block with the following slots:

| Slot | Kind | Size | Notes |
|---|---|---|---|
| 0 | 32-bit memory | 256 bytes | Below the 4 KiB floor |
| 1 | I/O | 20 bytes | Not a power of two |
| 2 | 64-bit memory | 6 GiB | Lower mask is zero; slot 3 is its upper half |
| 4 | I/O | 2 bytes | Below the 4-byte floor |
| 5 | Empty | — | — |

With these values, a single run reaches the following cases:
- Both rounding minimums.
- Rounding of a size that is not a power of two.
- A fully read-only lower dword.
- A paired upper dword with a mask other than all ones.
- An empty slot that ignores writes.

Capabilities are enabled, so the auto-set status flag and pointer are visible. The capability port is fed a read pattern derived from the forwarded address, so the bench can check both the routing and the returned data.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

  localparam int NUM_BARS = 6;

  // slot kind codes
  localparam logic [1:0] KIND_NONE  = 2'd0;
  localparam logic [1:0] KIND_IO    = 2'd1;
  localparam logic [1:0] KIND_MEM32 = 2'd2;
  localparam logic [1:0] KIND_MEM64 = 2'd3;

  // header dword indices
  localparam logic [3:0] DW_ID      = 4'd0;
  localparam logic [3:0] DW_CMDSTAT = 4'd1;
  localparam logic [3:0] DW_CLASS   = 4'd2;
  localparam logic [3:0] DW_BAR0    = 4'd4;
  localparam logic [3:0] DW_SUBSYS  = 4'd11;
  localparam logic [3:0] DW_CAPPTR  = 4'd13;
  localparam logic [3:0] DW_INTR    = 4'd15;

  localparam logic [15:0] CMD_WR_MASK   = 16'h0547;
  localparam logic [15:0] STAT_W1C_MASK = 16'hF900;
  localparam logic [15:0] STAT_CAP_BIT  = 16'h0010;
  localparam logic [7:0]  CAP_OFFSET    = 8'h40;

  typedef struct packed {
    logic                cmdWr;
    logic                statClr;
    logic [NUM_BARS-1:0] barWr;
    logic                rdCap;
  } hdrStrobe_t;

  // Complement of (size rounded up to a power of two, at least 2**minLog2) - 1
  function automatic logic [63:0] sizeMask(input logic [63:0] size, input int minLog2);
    int p;
    p = 63;
    for (int k = 63; k >= 0; k--) begin
      if (k >= minLog2 && (64'd1 << k) >= size) p = k;
    end
    return ~((64'd1 << p) - 64'd1);
  endfunction

  function automatic logic [31:0] barMask(input logic [2*NUM_BARS-1:0] kinds,
                                          input logic [64*NUM_BARS-1:0] sizes,
                                          input int idx);
    logic [1:0]  kind;
    logic [63:0] m;
    logic [31:0] res;
    kind = kinds[2*idx +: 2];
    m    = 64'd0;
    res  = 32'd0;
    if (kind == KIND_IO) begin
      m   = sizeMask(sizes[64*idx +: 64], 2);
      res = m[31:0];
    end else if (kind != KIND_NONE) begin
      m   = sizeMask(sizes[64*idx +: 64], 12);
      res = m[31:0];
    end else if (idx > 0) begin
      if (kinds[2*(idx-1) +: 2] == KIND_MEM64) begin
        m   = sizeMask(sizes[64*(idx-1) +: 64], 12);
        res = m[63:32];
      end
    end
    return res;
  endfunction

  function automatic logic [31:0] barInit(input logic [1:0] kind);
    case (kind)
      KIND_IO:    return 32'h0000_0001;
      KIND_MEM64: return 32'h0000_0004;
      default:    return 32'h0000_0000;
    endcase
  endfunction

endpackage

// File: rtl/cfg_hdr_ctrl.sv
module cfg_hdr_ctrl
  import cfg_hdr_pkg::*;
(
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic [9:0] reqAddr,
  input  logic [3:0] reqByteEn,
  output hdrStrobe_t strobe,
  output logic [3:0] dwIdx,
  output logic       capValid
);

  logic inHeader;
  logic hdrWrite;

  always_comb begin
    inHeader       = (reqAddr[9:4] == 6'd0);
    dwIdx          = reqAddr[3:0];
    hdrWrite       = reqValid && reqWrite && inHeader;
    strobe         = '0;
    strobe.rdCap   = !inHeader;
    strobe.cmdWr   = hdrWrite && (dwIdx == DW_CMDSTAT) && (reqByteEn[1:0] == 2'b11);
    strobe.statClr = hdrWrite && (dwIdx == DW_CMDSTAT) && (reqByteEn[3:2] == 2'b11);
    for (int i = 0; i < NUM_BARS; i++) begin
      strobe.barWr[i] = hdrWrite && (dwIdx == 4'(DW_BAR0 + i)) && (reqByteEn == 4'hF);
    end
    capValid = reqValid && !inHeader;
  end

endmodule

// File: rtl/cfg_hdr_dp.sv
module cfg_hdr_dp
  import cfg_hdr_pkg::*;
#(
  parameter logic [15:0]            VENDOR_ID        = 16'h1D0F,
  parameter logic [15:0]            DEVICE_ID        = 16'hA51C,
  parameter logic [7:0]             REVISION_ID      = 8'h03,
  parameter logic [23:0]            CLASS_CODE       = 24'h058000,
  parameter logic [15:0]            SUBSYS_VENDOR_ID = 16'h1D0F,
  parameter logic [15:0]            SUBSYS_ID        = 16'h0042,
  parameter logic [7:0]             INT_PIN          = 8'h01,
  parameter logic [2*NUM_BARS-1:0]  BAR_KINDS        = 12'h136,
  parameter logic [64*NUM_BARS-1:0] BAR_SIZES        = '0,
  parameter bit                     HAS_CAPS         = 1'b1
)(
  input  logic                   clk,
  input  logic                   rstN,
  input  hdrStrobe_t             strobe,
  input  logic [3:0]             dwIdx,
  input  logic [31:0]            wrData,
  input  logic [5:0]             errSet,
  input  logic [31:0]            capRdata,
  output logic [31:0]            rdData,
  output logic [15:0]            cmdOut,
  output logic [32*NUM_BARS-1:0] barOut
);

  localparam logic [15:0] STAT_FIXED = HAS_CAPS ? STAT_CAP_BIT : 16'h0000;
  localparam logic [7:0]  CAP_PTR    = HAS_CAPS ? CAP_OFFSET : 8'h00;

  logic [15:0] cmdReg;
  logic [15:0] statErr;
  logic [15:0] errBits;
  logic [15:0] statKept;
  logic [31:0] hdrRead;

  always_comb errBits = {errSet[5:1], 2'b00, errSet[0], 8'h00};

  always_comb begin
    statKept = statErr;
    if (strobe.statClr) statKept = statErr & ~(wrData[31:16] & STAT_W1C_MASK);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg  <= '0;
      statErr <= '0;
    end else begin
      if (strobe.cmdWr) cmdReg <= (cmdReg & ~CMD_WR_MASK) | (wrData[15:0] & CMD_WR_MASK);
      statErr <= statKept | errBits;
    end
  end

  for (genvar i = 0; i < NUM_BARS; i++) begin : g_bar
    localparam logic [31:0] MASK = barMask(BAR_KINDS, BAR_SIZES, i);
    localparam logic [31:0] INIT = barInit(BAR_KINDS[2*i +: 2]);
    logic [31:0] barReg;
    always_ff @(posedge clk) begin
      if (!rstN)                barReg <= INIT;
      else if (strobe.barWr[i]) barReg <= (barReg & ~MASK) | (wrData & MASK);
    end
    assign barOut[32*i +: 32] = barReg;
  end

  assign cmdOut = cmdReg;

  always_comb begin
    hdrRead = '0;
    case (dwIdx)
      DW_ID:      hdrRead = {DEVICE_ID, VENDOR_ID};
      DW_CMDSTAT: hdrRead = {statErr | STAT_FIXED, cmdReg};
      DW_CLASS:   hdrRead = {CLASS_CODE, REVISION_ID};
      DW_SUBSYS:  hdrRead = {SUBSYS_ID, SUBSYS_VENDOR_ID};
      DW_CAPPTR:  hdrRead = {24'h0, CAP_PTR};
      DW_INTR:    hdrRead = {16'h0, INT_PIN, 8'h00};
      default: begin
        for (int i = 0; i < NUM_BARS; i++) begin
          if (dwIdx == 4'(DW_BAR0 + i)) hdrRead = barOut[32*i +: 32];
        end
      end
    endcase
  end

  assign rdData = strobe.rdCap ? capRdata : hdrRead;

endmodule

// File: rtl/cfg_header_regs.sv
module cfg_header_regs
  import cfg_hdr_pkg::*;
#(
  parameter logic [15:0]            VENDOR_ID        = 16'h1D0F,
  parameter logic [15:0]            DEVICE_ID        = 16'hA51C,
  parameter logic [7:0]             REVISION_ID      = 8'h03,
  parameter logic [23:0]            CLASS_CODE       = 24'h058000,
  parameter logic [15:0]            SUBSYS_VENDOR_ID = 16'h1D0F,
  parameter logic [15:0]            SUBSYS_ID        = 16'h0042,
  parameter logic [7:0]             INT_PIN          = 8'h01,
  parameter logic [2*NUM_BARS-1:0]  BAR_KINDS        = 12'h136,
  parameter logic [64*NUM_BARS-1:0] BAR_SIZES        = {64'd0, 64'd2, 64'd0,
                                                        64'h1_8000_0000, 64'h14, 64'h100},
  parameter bit                     HAS_CAPS         = 1'b1
)(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic                   reqWrite,
  input  logic [9:0]             reqAddr,
  input  logic [3:0]             reqByteEn,
  input  logic [31:0]            reqWdata,
  output logic [31:0]            rspRdata,
  input  logic [5:0]             errSet,
  output logic [15:0]            cmdOut,
  output logic [32*NUM_BARS-1:0] barOut,
  output logic                   capValid,
  output logic                   capWrite,
  output logic [9:0]             capAddr,
  output logic [3:0]             capByteEn,
  output logic [31:0]            capWdata,
  input  logic [31:0]            capRdata
);

  hdrStrobe_t strobe;
  logic [3:0] dwIdx;

  cfg_hdr_ctrl u_ctrl (
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .reqByteEn(reqByteEn),
    .strobe   (strobe),
    .dwIdx    (dwIdx),
    .capValid (capValid)
  );

  cfg_hdr_dp #(
    .VENDOR_ID       (VENDOR_ID),
    .DEVICE_ID       (DEVICE_ID),
    .REVISION_ID     (REVISION_ID),
    .CLASS_CODE      (CLASS_CODE),
    .SUBSYS_VENDOR_ID(SUBSYS_VENDOR_ID),
    .SUBSYS_ID       (SUBSYS_ID),
    .INT_PIN         (INT_PIN),
    .BAR_KINDS       (BAR_KINDS),
    .BAR_SIZES       (BAR_SIZES),
    .HAS_CAPS        (HAS_CAPS)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .dwIdx   (dwIdx),
    .wrData  (reqWdata),
    .errSet  (errSet),
    .capRdata(capRdata),
    .rdData  (rspRdata),
    .cmdOut  (cmdOut),
    .barOut  (barOut)
  );

  assign capWrite  = reqWrite;
  assign capAddr   = reqAddr;
  assign capByteEn = reqByteEn;
  assign capWdata  = reqWdata;

endmodule

// File: rtl/cfg_hdr_chk.sv
module cfg_hdr_chk #(
  parameter bit HAS_CAPS = 1'b1
)(
  input logic         clk,
  input logic         rstN,
  input logic         reqValid,
  input logic         reqWrite,
  input logic [9:0]   reqAddr,
  input logic [31:0]  rspRdata,
  input logic         capValid,
  input logic [15:0]  cmdOut,
  input logic [191:0] barOut
);

  // R2
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && reqWrite) |=> $stable(cmdOut));

  // R4
  bar_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && reqWrite) |=> $stable(barOut));

  // R8
  rom_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && reqAddr == 10'd12) |=> ($stable(cmdOut) && $stable(barOut)));

  // R7
  cap_ptr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && reqAddr == 10'd13) |-> (rspRdata == (HAS_CAPS ? 32'h40 : 32'h0)));

  // R10
  cap_route_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqAddr >= 10'd16) |-> capValid);

  // R10
  cap_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqAddr < 10'd16) |-> !capValid);

  // R10
  cap_isolate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqAddr >= 10'd16) |=> ($stable(cmdOut) && $stable(barOut)));

endmodule

bind cfg_header_regs cfg_hdr_chk #(.HAS_CAPS(HAS_CAPS)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .reqValid(reqValid),
  .reqWrite(reqWrite),
  .reqAddr (reqAddr),
  .rspRdata(rspRdata),
  .capValid(capValid),
  .cmdOut  (cmdOut),
  .barOut  (barOut)
);

// File: tb/cfg_header_regs_tb.sv
`timescale 1ns/1ps
module cfg_header_regs_tb;

  localparam logic [15:0] VID  = 16'h1D0F;
  localparam logic [15:0] DID  = 16'hA51C;
  localparam logic [7:0]  REV  = 8'h03;
  localparam logic [23:0] CLS  = 24'h058000;
  localparam logic [15:0] SSV  = 16'h1D0F;
  localparam logic [15:0] SSID = 16'h0042;
  localparam logic [7:0]  PIN  = 8'h01;
  // expected masks and reset values, worked out by hand from R1, R5, R6
  localparam logic [31:0] BMASK [6] = '{32'hFFFFF000, 32'hFFFFFFE0, 32'h00000000,
                                        32'hFFFFFFFE, 32'hFFFFFFFC, 32'h00000000};
  localparam logic [31:0] BINIT [6] = '{32'h0, 32'h1, 32'h4, 32'h0, 32'h1, 32'h0};
  localparam int ERRPOS [6] = '{8, 11, 12, 13, 14, 15};

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0, reqWrite = 1'b0;
  logic [9:0]   reqAddr = '0;
  logic [3:0]   reqByteEn = '0;
  logic [31:0]  reqWdata = '0;
  logic [5:0]   errSet = '0;
  logic [31:0]  rspRdata, capWdata, capRdata;
  logic [15:0]  cmdOut;
  logic [191:0] barOut;
  logic         capValid, capWrite;
  logic [9:0]   capAddr;
  logic [3:0]   capByteEn;

  always #2.5 clk = ~clk;

  assign capRdata = {22'h155AA5, capAddr};

  cfg_header_regs #(
    .VENDOR_ID(VID), .DEVICE_ID(DID), .REVISION_ID(REV), .CLASS_CODE(CLS),
    .SUBSYS_VENDOR_ID(SSV), .SUBSYS_ID(SSID), .INT_PIN(PIN),
    .BAR_KINDS(12'h136),
    .BAR_SIZES({64'd0, 64'd2, 64'd0, 64'h1_8000_0000, 64'h14, 64'h100}),
    .HAS_CAPS(1'b1)
  ) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqByteEn(reqByteEn), .reqWdata(reqWdata),
    .rspRdata(rspRdata), .errSet(errSet), .cmdOut(cmdOut), .barOut(barOut),
    .capValid(capValid), .capWrite(capWrite), .capAddr(capAddr),
    .capByteEn(capByteEn), .capWdata(capWdata), .capRdata(capRdata)
  );

  int    compared = 0;
  int    mismatched = 0;
  string phase = "R1 reset";
  bit    started = 0;
  bit    done = 0;

  // behavioural reference state
  logic [15:0] mCmd;
  logic [15:0] mStat;
  logic [31:0] mBar [6];

  always @(posedge clk) begin
    started <= 1'b1;
    if (!rstN) begin
      mCmd  = '0;
      mStat = '0;
      for (int i = 0; i < 6; i++) mBar[i] = BINIT[i];
    end else begin
      if (reqValid && reqWrite && reqAddr < 10'd16) begin
        if (reqAddr == 10'd1 && reqByteEn[1:0] == 2'b11)
          for (int b = 0; b < 16; b++)
            if (b == 0 || b == 1 || b == 2 || b == 6 || b == 8 || b == 10) mCmd[b] = reqWdata[b];
        if (reqAddr == 10'd1 && reqByteEn[3:2] == 2'b11)
          for (int k = 0; k < 6; k++)
            if (reqWdata[16 + ERRPOS[k]]) mStat[ERRPOS[k]] = 1'b0;
        if (reqAddr >= 10'd4 && reqAddr <= 10'd9 && reqByteEn == 4'hF)
          mBar[reqAddr - 4] = (mBar[reqAddr - 4] & ~BMASK[reqAddr - 4]) |
                              (reqWdata & BMASK[reqAddr - 4]);
      end
      for (int k = 0; k < 6; k++) if (errSet[k]) mStat[ERRPOS[k]] = 1'b1;
    end
  end

  function automatic logic [31:0] expRd(input logic [9:0] a);
    if (a >= 10'd16) return {22'h155AA5, a};
    case (a)
      10'd0:  return {DID, VID};
      10'd1:  return {mStat | 16'h0010, mCmd};
      10'd2:  return {CLS, REV};
      10'd4, 10'd5, 10'd6, 10'd7, 10'd8, 10'd9: return mBar[a - 4];
      10'd11: return {SSID, SSV};
      10'd13: return 32'h0000_0040;
      10'd15: return {16'h0, PIN, 8'h00};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tagOf(input logic [9:0] a);
    if (a >= 10'd16) return "R10";
    if (a == 10'd1) return "R3";
    if (a >= 10'd4 && a <= 10'd9) return "R4/R5";
    if (a == 10'd12) return "R8";
    if (a == 10'd13) return "R7";
    return "R9";
  endfunction

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s [%s] actual=%h expected=%h at %0t", tag, phase, act, exp, $time);
    end
  endtask

  // compare on every falling edge, half a cycle after the state update
  always @(negedge clk) begin
    if (started && !done) begin
      cmp("R2", {16'h0, cmdOut}, {16'h0, mCmd});
      for (int i = 0; i < 6; i++) cmp((i == 3) ? "R4/R6" : "R4/R5", barOut[32*i +: 32], mBar[i]);
      cmp("R10", {31'h0, capValid}, {31'h0, reqValid && reqAddr >= 10'd16});
      if (reqValid && reqAddr >= 10'd16) cmp("R10", {22'h0, capAddr}, {22'h0, reqAddr});
      if (reqValid && !reqWrite) cmp(tagOf(reqAddr), rspRdata, expRd(reqAddr));
    end
  end

  task automatic drive(input logic v, input logic w, input logic [9:0] a,
                       input logic [3:0] be, input logic [31:0] d, input logic [5:0] e);
    @(negedge clk); #1;
    reqValid = v; reqWrite = w; reqAddr = a; reqByteEn = be; reqWdata = d; errSet = e;
  endtask

  task automatic rd(input logic [9:0] a);
    drive(1'b1, 1'b0, a, 4'hF, 32'h0, 6'h0);
  endtask

  task automatic wr(input logic [9:0] a, input logic [3:0] be, input logic [31:0] d);
    drive(1'b1, 1'b1, a, be, d, 6'h0);
  endtask

  task automatic idle(input logic [5:0] e);
    drive(1'b0, 1'b0, 10'd0, 4'h0, 32'h0, e);
  endtask

  task automatic readAll();
    for (int a = 0; a < 16; a++) rd(10'(a));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog [%s] actual=timeout expected=completion", phase);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    phase = "R1 reset";
    repeat (3) idle(6'h0);
    #1 rstN = 1'b1;
    phase = "R1 R9 reset values and identity";
    readAll();

    phase = "R2 command mask";
    wr(10'd1, 4'h3, 32'h0000_FFFF); rd(10'd1);
    wr(10'd1, 4'h1, 32'h0000_0000); rd(10'd1);
    wr(10'd1, 4'h3, 32'h0000_0105); rd(10'd1);

    phase = "R3 status set and clear";
    idle(6'h3F); rd(10'd1);
    wr(10'd1, 4'hC, 32'h0800_0000); rd(10'd1);
    wr(10'd1, 4'h4, 32'hFFFF_0000); rd(10'd1);
    wr(10'd1, 4'hC, 32'h06FF_0000); rd(10'd1);
    drive(1'b1, 1'b1, 10'd1, 4'hC, 32'h8000_0000, 6'b100000); rd(10'd1);
    wr(10'd1, 4'hF, 32'hFFFF_0000); rd(10'd1);

    phase = "R4 R5 R6 BAR masks";
    for (int i = 4; i <= 9; i++) begin wr(10'(i), 4'hF, 32'hFFFF_FFFF); rd(10'(i)); end
    for (int i = 4; i <= 9; i++) begin wr(10'(i), 4'hF, 32'h1234_5678); rd(10'(i)); end
    for (int i = 4; i <= 9; i++) begin wr(10'(i), 4'h7, 32'h0000_0000); rd(10'(i)); end
    for (int i = 4; i <= 9; i++) begin wr(10'(i), 4'hF, 32'h0000_0000); rd(10'(i)); end

    phase = "R7 capability pointer";
    rd(10'd13); rd(10'd1);

    phase = "R8 ignored header writes";
    wr(10'd1, 4'h3, 32'h0000_0547);
    wr(10'd4, 4'hF, 32'hABCD_E000);
    for (int a = 0; a < 16; a++)
      if (a != 1 && (a < 4 || a > 9)) wr(10'(a), 4'hF, 32'hFFFF_FFFF);
    readAll();

    phase = "R10 capability routing";
    rd(10'd16); rd(10'd100); rd(10'd1023);
    wr(10'd16, 4'hF, 32'hFFFF_FFFF); wr(10'd517, 4'h3, 32'h0000_FFFF);
    readAll();

    phase = "R1 reset mid-run";
    idle(6'h21);
    #1 rstN = 1'b0;
    idle(6'h0); idle(6'h0);
    #1 rstN = 1'b1;
    readAll();
    idle(6'h0); idle(6'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule